// File: doc/BRIEF.md
# Caption Erase and Autoblank Controller

This block sits beside the memory of a line-21 caption decoder. It watches the per-field waveform detector, the arrival of valid data for the selected channel, the video lock status, the display mode and the decoded erase commands. From these it decides when the visible and hidden character memories must be wiped, and whether the decoder picture is shown at all. All timing is counted in fields: a one-cycle `tick_i` pulse arrives once per video field.

The autoblank part uses two hysteresis windows. A waveform must be seen on `ACQ_TICKS` consecutive fields before the decoder leaves the pass-through state. Once established, it is dropped only after `LOSS_TICKS` consecutive fields with neither a waveform nor channel data. A separate inactivity timer wipes the visible memory after `IDLE_TICKS` fields without data. This timer runs only in caption and data-service modes. Mode changes, loss of video lock and the erase commands of each mode also produce erase strobes. When several causes coincide, they merge into one strobe per memory.

Top module: `cc_blank_ctrl`

## Requirements
- R1: After reset, `erase_disp_o`, `erase_hid_o` and `keep_box_o` are low, and the waveform state is absent, so `disp_en_o` is low even while `dec_on_i` is high.
- R2: While absent, a waveform seen on `ACQ_TICKS` consecutive ticks makes the state present. A tick without a waveform restarts the count.
- R3: While present, `LOSS_TICKS` consecutive ticks with no waveform and no `data_i` make the state absent and give one `erase_disp_o` strobe. Either a waveform tick or a `data_i` pulse restarts the loss count.
- R4: When `idle_en_i` is high and the mode is caption or data service, `IDLE_TICKS` ticks with no `data_i` give one `erase_disp_o` strobe. The strobe does not repeat until `data_i` arrives again. The timer does nothing in text mode or while `idle_en_i` is low.
- R5: An inactivity erase leaves `disp_en_o` unchanged and does not touch the hidden memory.
- R6: A change of `mode_i` strobes both `erase_disp_o` and `erase_hid_o`. The encoding of `mode_i` is: 3'b0cc is caption channel cc+1, 3'b10t is text channel t+1, and 3'b11x is data service.
- R7: A falling edge of `vlock_i` strobes `erase_disp_o` only. The mode is kept, so the same `mode_i` on the next cycle causes no erase.
- R8: In caption modes, `cmd_edm_i` erases the visible memory and `cmd_enm_i` erases the hidden memory. In text modes, `cmd_stxt_i` erases the visible memory and raises `keep_box_o` with the strobe. Commands given in any other mode are ignored.
- R9: Every erase output is a strobe one clock cycle long, registered one cycle after its cause. Coinciding causes give a single strobe per memory. `keep_box_o` is high only when start-text is the sole cause of the visible erase.
- R10: `disp_en_o` is high exactly when `dec_on_i` is high and the waveform state is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per video field |
| wave_i | input | 1 | Waveform present in this field (sampled with tick) |
| data_i | input | 1 | Valid data for the selected channel arrived |
| vlock_i | input | 1 | Video lock status |
| mode_i | input | 3 | Selected display mode |
| cmd_edm_i | input | 1 | Erase-visible-memory command |
| cmd_enm_i | input | 1 | Erase-hidden-memory command |
| cmd_stxt_i | input | 1 | Start-text command |
| dec_on_i | input | 1 | User request for decoder on |
| idle_en_i | input | 1 | Enables the inactivity erase timer |
| erase_disp_o | output | 1 | Visible memory erase strobe |
| erase_hid_o | output | 1 | Hidden memory erase strobe |
| keep_box_o | output | 1 | Box is kept with this visible erase |
| disp_en_o | output | 1 | Decoder picture shown |

## Verification
A table of mode and command vectors walks through every mode class. It separates commands that are honoured from those that must be ignored, and it separates plain mode changes from command erases. Acquisition runs stop one tick short of the threshold and after an interrupted run, which tells consecutive counting apart from cumulative counting. The loss and inactivity runs place a data pulse late in the window, which shows whether data truly restarts each counter. The runs then stop one tick short and land exactly on the threshold to check the boundary. Coinciding causes, including lock loss together with a command, show whether strobes merge and whether the box flag is suppressed.

// File: rtl/cc_blank_pkg.sv
package cc_blank_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        KIND_CAPTION = 2'd0,
        KIND_TEXT    = 2'd1,
        KIND_SERVICE = 2'd2
    } mode_kind_e;

    function automatic mode_kind_e kind_of(input logic [MODE_W-1:0] m);
        if (!m[2]) begin
            return KIND_CAPTION;
        end else if (!m[1]) begin
            return KIND_TEXT;
        end
        return KIND_SERVICE;
    endfunction

endpackage

// File: rtl/cc_wave_presence.sv
module cc_wave_presence #(
    parameter int ACQ_TICKS  = 30,
    parameter int LOSS_TICKS = 90
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic wave_i,
    input  logic data_i,
    output logic present_o,
    output logic lost_o
);
    localparam int MAXT = (ACQ_TICKS > LOSS_TICKS) ? ACQ_TICKS : LOSS_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_TICKS - 1);
    localparam logic [CW-1:0] LOSS_LAST = CW'(LOSS_TICKS - 1);

    typedef struct packed {
        logic          present;
        logic [CW-1:0] cnt;
    } pres_t;

    pres_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        lost_o = 1'b0;
        if (!st_q.present) begin
            if (tick_i) begin
                if (!wave_i) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == ACQ_LAST) begin
                    st_d.present = 1'b1;
                    st_d.cnt     = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            if (data_i) begin
                st_d.cnt = '0;
            end else if (tick_i) begin
                if (wave_i) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LOSS_LAST) begin
                    st_d.present = 1'b0;
                    st_d.cnt     = '0;
                    lost_o       = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign present_o = st_q.present;

    assert_acq_needs_wave_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.present) |-> $past(tick_i && wave_i));

    assert_loss_needs_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.present) |-> $past(tick_i && !wave_i && !data_i));

    assert_data_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.present && data_i) |=> st_q.present);

endmodule

// File: rtl/cc_idle_eraser.sv
module cc_idle_eraser #(
    parameter int IDLE_TICKS = 960
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic data_i,
    input  logic active_i,
    input  logic restart_i,
    output logic fire_o
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);

    typedef struct packed {
        logic          fired;
        logic [CW-1:0] cnt;
    } idle_t;

    idle_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (!active_i || data_i || restart_i) begin
            st_d = '0;
        end else if (tick_i && !st_q.fired) begin
            if (st_q.cnt == IDLE_LAST) begin
                st_d.fired = 1'b1;
                st_d.cnt   = '0;
                fire_o     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_idle_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.fired) |-> $past(tick_i && active_i && !data_i));

    assert_idle_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fired && active_i && !data_i && !restart_i) |=> st_q.fired);

endmodule

// File: rtl/cc_blank_ctrl.sv
module cc_blank_ctrl
    import cc_blank_pkg::*;
#(
    parameter int ACQ_TICKS  = 30,
    parameter int LOSS_TICKS = 90,
    parameter int IDLE_TICKS = 960
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wave_i,
    input  logic              data_i,
    input  logic              vlock_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cmd_edm_i,
    input  logic              cmd_enm_i,
    input  logic              cmd_stxt_i,
    input  logic              dec_on_i,
    input  logic              idle_en_i,
    output logic              erase_disp_o,
    output logic              erase_hid_o,
    output logic              keep_box_o,
    output logic              disp_en_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              vlock;
        logic              erase_disp;
        logic              erase_hid;
        logic              keep_box;
    } ctrl_t;

    ctrl_t      r_d, r_q;
    logic       present;
    logic       lost;
    logic       idle_fire;
    logic       mode_chg;
    logic       idle_active;
    mode_kind_e kind;

    always_comb begin
        kind        = kind_of(mode_i);
        mode_chg    = (mode_i != r_q.mode);
        idle_active = idle_en_i && (kind != KIND_TEXT);
    end

    cc_wave_presence #(
        .ACQ_TICKS (ACQ_TICKS),
        .LOSS_TICKS(LOSS_TICKS)
    ) i_presence (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .wave_i   (wave_i),
        .data_i   (data_i),
        .present_o(present),
        .lost_o   (lost)
    );

    cc_idle_eraser #(
        .IDLE_TICKS(IDLE_TICKS)
    ) i_idle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .data_i   (data_i),
        .active_i (idle_active),
        .restart_i(mode_chg),
        .fire_o   (idle_fire)
    );

    always_comb begin
        logic stxt_hit;
        logic other_disp;
        r_d       = r_q;
        r_d.mode  = mode_i;
        r_d.vlock = vlock_i;
        stxt_hit  = cmd_stxt_i && (kind == KIND_TEXT);
        other_disp = mode_chg
                   || (r_q.vlock && !vlock_i)
                   || lost
                   || idle_fire
                   || (cmd_edm_i && (kind == KIND_CAPTION));
        r_d.erase_disp = other_disp || stxt_hit;
        r_d.erase_hid  = mode_chg || (cmd_enm_i && (kind == KIND_CAPTION));
        r_d.keep_box   = stxt_hit && !other_disp;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.vlock <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign erase_disp_o = r_q.erase_disp;
    assign erase_hid_o  = r_q.erase_hid;
    assign keep_box_o   = r_q.keep_box;
    assign disp_en_o    = dec_on_i && present;

    assert_box_with_erase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        keep_box_o |-> erase_disp_o);

    assert_mode_chg_erases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.mode != $past(r_q.mode)) |-> (erase_disp_o && erase_hid_o));

    assert_lock_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(vlock_i) |=> erase_disp_o);

    assert_loss_erases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(present) |-> erase_disp_o);

endmodule

// File: tb/test_cc_blank_ctrl.sv
`timescale 1ns/1ps
module test_cc_blank_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wave = 1'b0, data = 1'b0, vlock = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       edm = 1'b0, enm = 1'b0, stxt = 1'b0, dec_on = 1'b1, idle_en = 1'b0;
    logic       erase_disp, erase_hid, keep_box, disp_en;
    int         total = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    cc_blank_ctrl i_cc_blank_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wave_i(wave), .data_i(data),
        .vlock_i(vlock), .mode_i(mode), .cmd_edm_i(edm), .cmd_enm_i(enm),
        .cmd_stxt_i(stxt), .dec_on_i(dec_on), .idle_en_i(idle_en),
        .erase_disp_o(erase_disp), .erase_hid_o(erase_hid),
        .keep_box_o(keep_box), .disp_en_o(disp_en)
    );

    // {mode[2:0], edm, enm, stxt, exp_disp, exp_hid, exp_box}
    localparam logic [8:0] VEC [12] = '{
        {3'd0, 3'b100, 3'b100},  // R8 caption EDM
        {3'd0, 3'b010, 3'b010},  // R8 caption ENM
        {3'd0, 3'b001, 3'b000},  // R8 start-text ignored in caption
        {3'd4, 3'b000, 3'b110},  // R6 change to text
        {3'd4, 3'b001, 3'b101},  // R8 start-text keeps box
        {3'd4, 3'b100, 3'b000},  // R8 EDM ignored in text
        {3'd4, 3'b010, 3'b000},  // R8 ENM ignored in text
        {3'd6, 3'b001, 3'b110},  // R6 change to service, start-text ignored
        {3'd6, 3'b100, 3'b000},  // R8 EDM ignored in service
        {3'd1, 3'b100, 3'b110},  // R9 change plus EDM merge
        {3'd1, 3'b000, 3'b000},  // R6 no change, no erase
        {3'd1, 3'b110, 3'b110}   // R9 EDM plus ENM
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // run n cycles, returning how many carried each strobe
    task automatic run(input int n, output int nd, output int nh);
        nd = 0;
        nh = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            nd += int'(erase_disp);
            nh += int'(erase_hid);
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        int nd, nh;
        repeat (3) cyc();
        // R1 reset state
        chk("R1 erase_disp", int'(erase_disp), 0);
        chk("R1 erase_hid", int'(erase_hid), 0);
        chk("R1 keep_box", int'(keep_box), 0);
        chk("R1 disp_en", int'(disp_en), 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 after release", int'(erase_disp | erase_hid | disp_en), 0);

        for (int v = 0; v < 12; v++) begin
            {mode, edm, enm, stxt} = VEC[v][8:3];
            cyc();
            chk($sformatf("R8/R6/R9 vec%0d disp", v), int'(erase_disp), int'(VEC[v][2]));
            chk($sformatf("R8/R6/R9 vec%0d hid", v), int'(erase_hid), int'(VEC[v][1]));
            chk($sformatf("R8/R9 vec%0d box", v), int'(keep_box), int'(VEC[v][0]));
        end
        {edm, enm, stxt} = 3'b000;
        cyc();

        // R2 acquisition, interrupted run restarts
        tick = 1'b1; wave = 1'b1;
        run(29, nd, nh);
        chk("R2 29 ticks still absent", int'(disp_en), 0);
        wave = 1'b0;
        cyc();
        wave = 1'b1;
        run(29, nd, nh);
        chk("R2 restart after gap", int'(disp_en), 0);
        cyc();
        chk("R2 R10 present after full run", int'(disp_en), 1);
        dec_on = 1'b0;
        #1;
        chk("R10 request off", int'(disp_en), 0);
        dec_on = 1'b1;
        #1;

        // R3 loss window with data restart
        wave = 1'b0;
        run(89, nd, nh);
        chk("R3 no erase before window", nd, 0);
        chk("R3 still present", int'(disp_en), 1);
        data = 1'b1;
        cyc();
        data = 1'b0;
        run(89, nd, nh);
        chk("R3 data restarted count", nd, 0);
        chk("R3 still present after restart", int'(disp_en), 1);
        cyc();
        chk("R3 loss strobe", int'(erase_disp), 1);
        chk("R3 loss hidden untouched", int'(erase_hid), 0);
        chk("R3 R10 blanked", int'(disp_en), 0);
        cyc();
        chk("R9 loss strobe single", int'(erase_disp), 0);

        // reacquire, then R4 inactivity timer in caption mode
        wave = 1'b1;
        run(30, nd, nh);
        chk("R2 reacquired", int'(disp_en), 1);
        idle_en = 1'b1;
        run(959, nd, nh);
        chk("R4 no idle erase early", nd, 0);
        cyc();
        chk("R4 idle erase", int'(erase_disp), 1);
        chk("R5 hidden untouched", int'(erase_hid), 0);
        chk("R5 decoder stays on", int'(disp_en), 1);
        run(100, nd, nh);
        chk("R4 no repeat", nd, 0);
        data = 1'b1;
        cyc();
        data = 1'b0;
        run(959, nd, nh);
        chk("R4 rearmed early", nd, 0);
        cyc();
        chk("R4 rearmed fires", int'(erase_disp), 1);

        // R4 idle off in text mode
        mode = 3'd4;
        cyc();
        chk("R6 change to text", int'(erase_disp & erase_hid), 1);
        run(1000, nd, nh);
        chk("R4 text mode silent", nd, 0);
        mode = 3'd7;
        cyc();
        chk("R6 change to service", int'(erase_hid), 1);
        run(960, nd, nh);
        chk("R4 service mode fires once", nd, 1);
        mode = 3'd0; idle_en = 1'b0;
        cyc();
        run(1000, nd, nh);
        chk("R4 disabled silent", nd, 0);

        // R7 lock loss merged with EDM
        tick = 1'b0;
        vlock = 1'b0; edm = 1'b1;
        cyc();
        edm = 1'b0;
        chk("R7 lock loss erase", int'(erase_disp), 1);
        chk("R7 hidden untouched", int'(erase_hid), 0);
        cyc();
        chk("R9 merged single strobe", int'(erase_disp), 0);
        chk("R7 mode kept", int'(erase_hid), 0);
        vlock = 1'b1;
        cyc();
        chk("R7 relock no erase", int'(erase_disp), 0);

        // R9 start-text with lock loss drops box
        mode = 3'd5;
        cyc();
        vlock = 1'b0; stxt = 1'b1;
        cyc();
        stxt = 1'b0;
        chk("R9 merged disp", int'(erase_disp), 1);
        chk("R9 box dropped", int'(keep_box), 0);
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end
endmodule